// File: doc/BRIEF.md
# Brush Rectangle Paint Engine

This block draws rectangular brush stamps into a frame buffer that sits in a memory shared with other users. A caller gives a cursor position, a brush width and height, and a color code, then pulses a strobe. The engine captures those values and writes the selected color to every pixel of the rectangle whose top-left corner is the cursor. It trims away any part of that rectangle that lies past the right or bottom edge of the screen.

Each pixel goes out through a request/grant write port. The memory is also read by a display refresh path, so an arbiter may hold off the grant for any number of cycles. The engine holds its request, address and data steady until the grant arrives, and moves on by exactly one pixel for each granted cycle. Color code 0 is the eraser: it writes the background value instead of itself.

Top module: `brush_paint_engine`

## Requirements
- R1: After reset, `busy_o` and `mem_req_o` are low.
- R2: Each write targets address `y*720 + x` for a pixel at column `x` and line `y` of a 720 by 487 screen, with the cursor at the top-left corner of the rectangle. The data is the latched color code when that code is not 0.
- R3: Pixels are written in row-major order: left to right within a line, then line by line downward. Exactly one pixel is written per cycle in which `mem_req_o` and `mem_gnt_i` are both high at the clock edge.
- R4: A strobe captures cursor, size and color. When the trimmed region is not empty, `busy_o` is high from the cycle after the strobe until the edge that completes the last pixel write, and low in the following cycle. `mem_req_o` is high only while `busy_o` is high.
- R5: While the grant is withheld, `mem_req_o` stays high and `mem_addr_o` and `mem_data_o` hold their values.
- R6: Columns at or beyond 720 and lines at or beyond 487 are skipped, and the rest of the rectangle is still written.
- R7: A strobe that arrives while `busy_o` is high has no effect: the running stroke completes with its own pixels and color, and no extra writes follow.
- R8: Color code 0 (erase) writes the background value 8'hFF to each pixel.
- R9: A strobe with zero width, zero height, or a cursor outside the screen produces no write, and `busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| paint_i | input | 1 | Paint strobe, one cycle |
| cur_x_i | input | 10 | Cursor column (rectangle left edge) |
| cur_y_i | input | 9 | Cursor line (rectangle top edge) |
| brush_w_i | input | 7 | Brush width in pixels |
| brush_h_i | input | 7 | Brush height in lines |
| color_i | input | 8 | Color code, 0 means erase |
| busy_o | output | 1 | Stroke in progress |
| mem_req_o | output | 1 | Write request to the arbiter |
| mem_gnt_i | input | 1 | Grant; a write completes on an edge where request and grant are both high |
| mem_addr_o | output | 19 | Pixel address |
| mem_data_o | output | 8 | Pixel value |

## Verification
The hardest situation to reach is a second strobe landing while a stroke is still in progress. With a free-running grant the stroke is short and the window is only a few cycles wide. The bench therefore holds the grant low for many cycles, starts a stroke, and fires a conflicting strobe with different position, size and color into the stalled state. It then releases the grant and checks that only the original pixels appear. Uneven grant patterns from a shift register also exercise stalls on row turns and on the final pixel. A stamp at the bottom-right corner exercises trimming on both axes at once.

// File: rtl/paint_pkg.sv
package paint_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/paint_axis_clip.sv
module paint_axis_clip #(
    parameter int POS_W  = 10,
    parameter int SIZE_W = 7,
    parameter int LIMIT  = 720
) (
    input  logic [POS_W-1:0]  pos_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic [POS_W-1:0]  last_o,
    output logic              empty_o
);
    localparam int SUM_W = ((POS_W > SIZE_W) ? POS_W : SIZE_W) + 1;

    logic [SUM_W-1:0] far_edge;
    logic [SUM_W-1:0] top_limit;

    always_comb begin
        far_edge  = SUM_W'(pos_i) + SUM_W'(size_i) - SUM_W'(1);
        top_limit = SUM_W'(LIMIT - 1);
        empty_o   = (size_i == '0) || (SUM_W'(pos_i) > top_limit);
        if (far_edge > top_limit) begin
            last_o = POS_W'(LIMIT - 1);
        end else begin
            last_o = far_edge[POS_W-1:0];
        end
    end
endmodule

// File: rtl/paint_color_map.sv
module paint_color_map #(
    parameter int              COLOR_W  = 8,
    parameter logic [COLOR_W-1:0] BG_VALUE = 8'hFF
) (
    input  logic [COLOR_W-1:0] code_i,
    output logic [COLOR_W-1:0] pixel_o
);
    always_comb begin
        pixel_o = (code_i == '0) ? BG_VALUE : code_i;
    end
endmodule

// File: rtl/brush_paint_engine.sv
module brush_paint_engine #(
    parameter int                 SCREEN_W = 720,
    parameter int                 SCREEN_H = 487,
    parameter int                 SIZE_W   = 7,
    parameter int                 COLOR_W  = 8,
    parameter logic [COLOR_W-1:0] BG_VALUE = 8'hFF,
    localparam int                X_W      = $clog2(SCREEN_W),
    localparam int                Y_W      = $clog2(SCREEN_H),
    localparam int                ADDR_W   = $clog2(SCREEN_W * SCREEN_H)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               paint_i,
    input  logic [X_W-1:0]     cur_x_i,
    input  logic [Y_W-1:0]     cur_y_i,
    input  logic [SIZE_W-1:0]  brush_w_i,
    input  logic [SIZE_W-1:0]  brush_h_i,
    input  logic [COLOR_W-1:0] color_i,
    output logic               busy_o,
    output logic               mem_req_o,
    input  logic               mem_gnt_i,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [COLOR_W-1:0] mem_data_o
);
    import paint_pkg::*;

    typedef struct packed {
        phase_e             phase;
        logic [X_W-1:0]     x;
        logic [Y_W-1:0]     y;
        logic [X_W-1:0]     x_first;
        logic [X_W-1:0]     x_last;
        logic [Y_W-1:0]     y_last;
        logic [ADDR_W-1:0]  row_base;
        logic [ADDR_W-1:0]  addr;
        logic [COLOR_W-1:0] pixel;
    } state_t;

    state_t state_d, state_q;

    logic [X_W-1:0]     x_last_w;
    logic [Y_W-1:0]     y_last_w;
    logic               x_empty_w, y_empty_w;
    logic [COLOR_W-1:0] pixel_w;
    logic [ADDR_W-1:0]  start_base_w;
    logic               accept_w;

    paint_axis_clip #(.POS_W(X_W), .SIZE_W(SIZE_W), .LIMIT(SCREEN_W)) i_clip_x (
        .pos_i   (cur_x_i),
        .size_i  (brush_w_i),
        .last_o  (x_last_w),
        .empty_o (x_empty_w)
    );

    paint_axis_clip #(.POS_W(Y_W), .SIZE_W(SIZE_W), .LIMIT(SCREEN_H)) i_clip_y (
        .pos_i   (cur_y_i),
        .size_i  (brush_h_i),
        .last_o  (y_last_w),
        .empty_o (y_empty_w)
    );

    paint_color_map #(.COLOR_W(COLOR_W), .BG_VALUE(BG_VALUE)) i_color (
        .code_i  (color_i),
        .pixel_o (pixel_w)
    );

    always_comb begin
        state_d      = state_q;
        start_base_w = ADDR_W'(cur_y_i) * ADDR_W'(SCREEN_W);
        accept_w     = paint_i && (state_q.phase == PH_IDLE) && !x_empty_w && !y_empty_w;

        if (state_q.phase == PH_IDLE) begin
            if (accept_w) begin
                state_d.phase    = PH_RUN;
                state_d.x        = cur_x_i;
                state_d.y        = cur_y_i;
                state_d.x_first  = cur_x_i;
                state_d.x_last   = x_last_w;
                state_d.y_last   = y_last_w;
                state_d.row_base = start_base_w;
                state_d.addr     = start_base_w + ADDR_W'(cur_x_i);
                state_d.pixel    = pixel_w;
            end
        end else if (mem_gnt_i) begin
            if (state_q.x == state_q.x_last) begin
                if (state_q.y == state_q.y_last) begin
                    state_d.phase = PH_IDLE;
                end else begin
                    state_d.y        = state_q.y + Y_W'(1);
                    state_d.x        = state_q.x_first;
                    state_d.row_base = state_q.row_base + ADDR_W'(SCREEN_W);
                    state_d.addr     = state_q.row_base + ADDR_W'(SCREEN_W)
                                     + ADDR_W'(state_q.x_first);
                end
            end else begin
                state_d.x    = state_q.x + X_W'(1);
                state_d.addr = state_q.addr + ADDR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy_o     = (state_q.phase == PH_RUN);
    assign mem_req_o  = (state_q.phase == PH_RUN);
    assign mem_addr_o = state_q.addr;
    assign mem_data_o = state_q.pixel;
endmodule

// File: rtl/paint_engine_checker.sv
module paint_engine_checker #(
    parameter int ADDR_W  = 19,
    parameter int COLOR_W = 8,
    parameter int PIXELS  = 720 * 487
) (
    input logic               clk,
    input logic               rst_n,
    input logic               paint_i,
    input logic               busy_o,
    input logic               mem_req_o,
    input logic               mem_gnt_i,
    input logic [ADDR_W-1:0]  mem_addr_o,
    input logic [COLOR_W-1:0] mem_data_o
);
    // R2: every requested address lies inside the frame buffer
    a_r2_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (32'(mem_addr_o) < 32'(PIXELS)));

    // R4: requests only while busy
    a_r4_req_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> busy_o);

    // R4: a stroke begins only after a strobe
    a_r4_busy_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(paint_i));

    // R5: a refused request is held unchanged
    a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_gnt_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o)));

    // R7: a stroke keeps its color and cannot be cut short without a grant
    a_r7_stroke_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !(mem_req_o && mem_gnt_i)) |=> (busy_o && $stable(mem_data_o)));
endmodule

bind brush_paint_engine paint_engine_checker #(
    .ADDR_W  (ADDR_W),
    .COLOR_W (COLOR_W),
    .PIXELS  (SCREEN_W * SCREEN_H)
) i_paint_engine_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .paint_i    (paint_i),
    .busy_o     (busy_o),
    .mem_req_o  (mem_req_o),
    .mem_gnt_i  (mem_gnt_i),
    .mem_addr_o (mem_addr_o),
    .mem_data_o (mem_data_o)
);

// File: tb/test_brush_paint_engine.sv
module test_brush_paint_engine;
    localparam int W  = 720;
    localparam int H  = 487;
    localparam logic [7:0] BG = 8'hFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        paint_i = 1'b0;
    logic [9:0]  cur_x_i = '0;
    logic [8:0]  cur_y_i = '0;
    logic [6:0]  brush_w_i = '0;
    logic [6:0]  brush_h_i = '0;
    logic [7:0]  color_i = '0;
    logic        busy_o, mem_req_o;
    logic        mem_gnt_i = 1'b0;
    logic [18:0] mem_addr_o;
    logic [7:0]  mem_data_o;

    int errors = 0;
    int checks = 0;
    int gmode  = 0;          // 0 always grant, 1 shift-register pattern, 2 never
    logic [7:0] lfsr = 8'hA5;
    logic last_pending = 1'b0;
    logic running = 1'b0;

    typedef struct { logic [18:0] addr; logic [7:0] data; } item_t;
    item_t exp_q[$];

    always #4 clk = ~clk;    // 125 MHz

    brush_paint_engine i_brush_paint_engine (
        .clk(clk), .rst_n(rst_n), .paint_i(paint_i),
        .cur_x_i(cur_x_i), .cur_y_i(cur_y_i),
        .brush_w_i(brush_w_i), .brush_h_i(brush_h_i), .color_i(color_i),
        .busy_o(busy_o), .mem_req_o(mem_req_o), .mem_gnt_i(mem_gnt_i),
        .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // grant driver and monitor, both away from the active edge
    always @(negedge clk) begin
        if (last_pending) begin
            last_pending = 1'b0;
            check(!busy_o, "R4", "busy after last pixel", busy_o, 0);
        end
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (gmode)
            0: mem_gnt_i = 1'b1;
            1: mem_gnt_i = lfsr[0] & lfsr[2];
            default: mem_gnt_i = 1'b0;
        endcase
        if (running && mem_req_o && mem_gnt_i) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 R9", "unexpected write addr", int'(mem_addr_o), -1);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check(mem_addr_o == e.addr, "R2 R3 R6", "address", int'(mem_addr_o), int'(e.addr));
                check(mem_data_o == e.data, "R2 R8", "data", int'(mem_data_o), int'(e.data));
                if (exp_q.size() == 0) last_pending = 1'b1;
            end
        end
    end

    task automatic push_expected(input int x, input int y, input int w, input int h,
                                 input logic [7:0] c);
        for (int yy = y; yy < y + h; yy++) begin
            for (int xx = x; xx < x + w; xx++) begin
                if (xx < W && yy < H) begin
                    item_t e;
                    e.addr = 19'(yy * W + xx);
                    e.data = (c == 8'd0) ? BG : c;
                    exp_q.push_back(e);
                end
            end
        end
    endtask

    task automatic strobe(input int x, input int y, input int w, input int h,
                          input logic [7:0] c);
        @(negedge clk);
        cur_x_i = 10'(x); cur_y_i = 9'(y);
        brush_w_i = 7'(w); brush_h_i = 7'(h); color_i = c;
        paint_i = 1'b1;
        @(negedge clk);
        paint_i = 1'b0;
        cur_x_i = '0; cur_y_i = '0; brush_w_i = '0; brush_h_i = '0; color_i = 8'h55;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000 && (busy_o || exp_q.size() != 0 || last_pending); i++)
            @(negedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R3", "pixels left unwritten", exp_q.size(), 0);
        check(!busy_o, "R4", "busy at stroke end", busy_o, 0);
    endtask

    task automatic stroke(input int x, input int y, input int w, input int h,
                          input logic [7:0] c, input bit nonempty);
        push_expected(x, y, w, h, c);
        strobe(x, y, w, h, c);
        // one negedge after the strobe: busy must reflect the latched region
        check(busy_o == nonempty, nonempty ? "R4" : "R9", "busy after strobe",
              busy_o, int'(nonempty));
        wait_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !mem_req_o, "R1", "busy/req in reset", {busy_o, mem_req_o}, 0);
        rst_n = 1'b1;
        running = 1'b1;
        @(negedge clk);
        check(!busy_o && !mem_req_o, "R1", "busy/req after reset", {busy_o, mem_req_o}, 0);

        gmode = 0;
        stroke(10, 20, 4, 3, 8'h05, 1'b1);           // R2 R3 basic
        gmode = 1;
        stroke(100, 200, 6, 5, 8'h00, 1'b1);          // R8 erase, R5 stalls
        stroke(715, 484, 10, 10, 8'h3C, 1'b1);        // R6 both edges trimmed
        stroke(719, 486, 1, 1, 8'h07, 1'b1);          // R6 last pixel of screen
        gmode = 0;
        stroke(0, 0, 127, 2, 8'h09, 1'b1);            // R3 wide rows

        // R9 empty regions
        stroke(720, 5, 3, 3, 8'h11, 1'b0);
        stroke(5, 487, 3, 3, 8'h11, 1'b0);
        stroke(30, 30, 0, 4, 8'h11, 1'b0);
        stroke(30, 30, 4, 0, 8'h11, 1'b0);

        // R7: strobe during a stalled stroke is ignored
        gmode = 2;
        push_expected(50, 60, 3, 2, 8'h21);
        strobe(50, 60, 3, 2, 8'h21);
        repeat (4) @(negedge clk);
        check(mem_addr_o == 19'(60 * W + 50), "R5", "held address", int'(mem_addr_o), 60 * W + 50);
        strobe(400, 300, 9, 9, 8'h77);
        repeat (3) @(negedge clk);
        check(mem_data_o == 8'h21, "R7", "color kept", int'(mem_data_o), 8'h21);
        gmode = 1;
        wait_done();
        repeat (20) @(negedge clk);
        check(!mem_req_o, "R7", "no extra request", mem_req_o, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(150000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule